// File: doc/BRIEF.md
# Multicycle 16-bit Execute Sequencer

This block is the control and datapath core of a small 16-bit register machine that works through every instruction in numbered timing steps. One step counter selects the datapath action for each clock cycle. The first three steps fetch the instruction word from memory and advance the program counter. The steps after that carry out multiply, divide, jump-if-positive or displaced load, each in a fixed number of steps. The core holds eight general registers, the program counter, the instruction register, an input buffer in front of the arithmetic unit, and a pair of result registers for the low and high halves of a wide result.

Memory is reached through one synchronous read port. A read requested during one step returns its word in the following step. Each register write goes through the single internal bus, so only one register changes per step. For that reason a 32-bit product or a quotient/remainder pair is written back over two steps. The `run` input allows a new fetch whenever the sequencer is at step 0. Every register-file write appears on a write-back observation port, so the integrating logic or a bench can follow the results.

Top module: `seqcpu_core`

## Requirements
- R1: Fetch takes steps T0, T1 and T2 for every instruction. T0 reads memory at `pc`. T1 latches the returned word as the instruction and adds one to `pc`. After the last step of an instruction the step counter returns to T0.
- R2: Instruction word layout: opcode in bits [15:11], ra in [10:8], rb in [7:5], rc in [4:2], a 5-bit signed load offset in [4:0] and an 8-bit signed jump displacement in [7:0]. The opcodes are divide = 5, multiply = 7, jump-if-positive = 16 and load = 29.
- R3: Multiply takes 7 steps. It forms the unsigned 32-bit product of R[rb] and R[rc]. It writes the high half to R0 in T5, then the low half to R[ra] in T6.
- R4: Divide takes 7 steps. It divides the unsigned 32-bit value {R0, R[rb]} by R[rc]. It writes the remainder to R0 in T5, then the low 16 bits of the quotient to R[ra] in T6.
- R5: A divide whose divisor is zero ends after T4 (5 steps). It writes no register and sets `div_err`. Once set, `div_err` stays set until reset.
- R6: Jump-if-positive takes 5 steps. When R[ra] bit 15 is clear (zero included), `pc` becomes the incremented `pc` plus the sign-extended displacement. Otherwise `pc` keeps the incremented value.
- R7: Load takes 5 steps. In T3 it reads memory at R[rb] plus the sign-extended offset. In T4 it writes the returned word to R[ra].
- R8: Any other opcode is a no-operation lasting exactly the 3 fetch steps. It writes no register and leaves `pc` at its incremented value.
- R9: At T0 with `run` low the sequencer stays idle: `step` remains 0, `pc` does not change and `busy` is low. `busy` is high in every step other than T0, and during T0 when `run` is high.
- R10: After reset `pc` is 0, `step` is 0, all registers are 0, `div_err` is low and no write is signalled.
- R11: `wb_en`, `wb_idx` and `wb_data` show every register-file write in the step that performs it. Writes happen only in T4, T5 or T6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows a new fetch when the sequencer is at T0 |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory word address |
| mem_rdata | input | 16 | Read data, valid in the step after the request |
| busy | output | 1 | Instruction in progress |
| step | output | 3 | Current timing step (0 to 6) |
| pc | output | 16 | Program counter |
| wb_en | output | 1 | Register-file write in this step |
| wb_idx | output | 3 | Register being written |
| wb_data | output | 16 | Value being written |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
On every cycle the assertions check the step sequence, the idle hold at T0, the `busy` relation, that `pc` moves only in T1 or T4, that writes fall only in the execute window with the high half going to R0 first, and that the error flag is sticky. Only the directed scenarios can show the arithmetic itself: product and quotient/remainder values, sign extension of the load offset and jump displacement, the step count of each instruction class, and that a zero divisor and unknown opcodes leave the registers untouched.

// File: rtl/seqcpu_pkg.sv
package seqcpu_pkg;
   // instruction word layout
   localparam int INSTR_W = 16;
   localparam int OP_W    = 5;
   localparam int RIDX_W  = 3;
   localparam int OP_LSB  = 11;
   localparam int RA_LSB  = 8;
   localparam int RB_LSB  = 5;
   localparam int RC_LSB  = 2;
   localparam int IMM_W   = 5;
   localparam int DISP_W  = 8;

   localparam logic [OP_W-1:0] OPC_DIV  = 5'd5;
   localparam logic [OP_W-1:0] OPC_MUL  = 5'd7;
   localparam logic [OP_W-1:0] OPC_JPL  = 5'd16;
   localparam logic [OP_W-1:0] OPC_LOAD = 5'd29;

   localparam int STEP_W = 3;
   typedef enum logic [STEP_W-1:0] {
      ST_T0 = 3'd0, ST_T1 = 3'd1, ST_T2 = 3'd2, ST_T3 = 3'd3,
      ST_T4 = 3'd4, ST_T5 = 3'd5, ST_T6 = 3'd6, ST_RSV = 3'd7
   } step_t;
endpackage

// File: rtl/seqcpu_regfile.sv
module seqcpu_regfile #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx_a,
   input  logic [IDX_W-1:0]  ridx_b,
   input  logic [IDX_W-1:0]  ridx_c,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b,
   output logic [DATA_W-1:0] rdata_c,
   output logic [DATA_W-1:0] rdata_r0
);
   logic [DATA_W-1:0] regs_q [NREGS];

   generate
      if (NREGS < 2) begin : g_bad_depth
         $error("seqcpu_regfile: NREGS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREGS; i++) begin
         if (!rst_n)
            regs_q[i] <= '0;
         else if (we && (widx == IDX_W'(i)))
            regs_q[i] <= wdata;
      end
   end

   assign rdata_a  = regs_q[ridx_a];
   assign rdata_b  = regs_q[ridx_b];
   assign rdata_c  = regs_q[ridx_c];
   assign rdata_r0 = regs_q[0];
endmodule

// File: rtl/seqcpu_alsu.sv
module seqcpu_alsu #(
   parameter int DATA_W = 16,
   localparam int WIDE_W = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] buf_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] hi_part,
   output logic [WIDE_W-1:0] product,
   output logic [DATA_W-1:0] quotient,
   output logic [DATA_W-1:0] remainder,
   output logic              div_zero
);
   logic [WIDE_W-1:0] dividend;
   logic [WIDE_W-1:0] divisor;

   assign product  = WIDE_W'(buf_a) * WIDE_W'(opnd_b);
   assign dividend = {hi_part, buf_a};
   assign divisor  = WIDE_W'(opnd_b);
   assign div_zero = (opnd_b == '0);

   always_comb begin
      if (div_zero) begin
         quotient  = '0;
         remainder = '0;
      end else begin
         quotient  = DATA_W'(dividend / divisor);
         remainder = DATA_W'(dividend % divisor);
      end
   end
endmodule

// File: rtl/seqcpu_stepctl.sv
module seqcpu_stepctl
   import seqcpu_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  logic  last,
   output step_t step,
   output logic  busy
);
   step_t step_d;

   always_comb begin
      if (last)
         step_d = ST_T0;
      else begin
         case (step)
            ST_T0:   step_d = run ? ST_T1 : ST_T0;
            ST_T1:   step_d = ST_T2;
            ST_T2:   step_d = ST_T3;
            ST_T3:   step_d = ST_T4;
            ST_T4:   step_d = ST_T5;
            ST_T5:   step_d = ST_T6;
            default: step_d = ST_T0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step <= ST_T0;
      else        step <= step_d;
   end

   assign busy = (step != ST_T0) || run;
endmodule

// File: rtl/seqcpu_core.sv
module seqcpu_core
   import seqcpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic              mem_rd,
   output logic [DATA_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic [2:0]        step,
   output logic [DATA_W-1:0] pc,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              div_err
);
   generate
      if (DATA_W != INSTR_W) begin : g_bad_width
         $error("seqcpu_core: DATA_W must equal the instruction width");
      end
      if (IDX_W != RIDX_W) begin : g_bad_regs
         $error("seqcpu_core: NREGS must match the register field width");
      end
   endgenerate

   step_t             st;
   logic              last;
   logic [DATA_W-1:0] ir_q, a_q, c_q, ch_q;
   logic              con_q;
   logic [DATA_W-1:0] ra_val, rb_val, rc_val, r0_val;
   logic [2*DATA_W-1:0] product;
   logic [DATA_W-1:0] quotient, remainder;
   logic              div_zero;

   // instruction fields
   logic [OP_W-1:0]   f_op;
   logic [IDX_W-1:0]  f_ra, f_rb, f_rc;
   logic [DATA_W-1:0] f_imm, f_disp;
   logic              is_mul, is_div, is_jpl, is_load, is_known;

   assign f_op   = ir_q[OP_LSB +: OP_W];
   assign f_ra   = ir_q[RA_LSB +: IDX_W];
   assign f_rb   = ir_q[RB_LSB +: IDX_W];
   assign f_rc   = ir_q[RC_LSB +: IDX_W];
   assign f_imm  = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign f_disp = {{(DATA_W-DISP_W){ir_q[DISP_W-1]}}, ir_q[DISP_W-1:0]};

   assign is_mul   = (f_op == OPC_MUL);
   assign is_div   = (f_op == OPC_DIV);
   assign is_jpl   = (f_op == OPC_JPL);
   assign is_load  = (f_op == OPC_LOAD);
   assign is_known = is_mul | is_div | is_jpl | is_load;

   seqcpu_stepctl i_stepctl (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .last  (last),
      .step  (st),
      .busy  (busy)
   );

   seqcpu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) i_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wb_en),
      .widx     (wb_idx),
      .wdata    (wb_data),
      .ridx_a   (f_ra),
      .ridx_b   (f_rb),
      .ridx_c   (f_rc),
      .rdata_a  (ra_val),
      .rdata_b  (rb_val),
      .rdata_c  (rc_val),
      .rdata_r0 (r0_val)
   );

   seqcpu_alsu #(.DATA_W(DATA_W)) i_alsu (
      .buf_a     (a_q),
      .opnd_b    (rc_val),
      .hi_part   (r0_val),
      .product   (product),
      .quotient  (quotient),
      .remainder (remainder),
      .div_zero  (div_zero)
   );

   // per-step control: memory port, write-back bus, end of instruction
   always_comb begin
      mem_rd   = 1'b0;
      mem_addr = pc;
      wb_en    = 1'b0;
      wb_idx   = f_ra;
      wb_data  = c_q;
      last     = 1'b0;
      case (st)
         ST_T0: mem_rd = run;
         ST_T2: last = !is_known;
         ST_T3: begin
            if (is_load) begin
               mem_rd   = 1'b1;
               mem_addr = rb_val + f_imm;
            end
         end
         ST_T4: begin
            if (is_load) begin
               wb_en   = 1'b1;
               wb_data = mem_rdata;
               last    = 1'b1;
            end
            if (is_jpl) last = 1'b1;
            if (is_div && div_zero) last = 1'b1;
         end
         ST_T5: begin
            wb_en   = 1'b1;
            wb_idx  = '0;
            wb_data = ch_q;
         end
         ST_T6: begin
            wb_en = 1'b1;
            last  = 1'b1;
         end
         default: ;
      endcase
   end

   // datapath registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc      <= '0;
         ir_q    <= '0;
         a_q     <= '0;
         c_q     <= '0;
         ch_q    <= '0;
         con_q   <= 1'b0;
         div_err <= 1'b0;
      end else begin
         case (st)
            ST_T1: begin
               ir_q <= mem_rdata;
               pc   <= pc + 1'b1;
            end
            ST_T3: begin
               a_q   <= rb_val;
               con_q <= !ra_val[DATA_W-1];
            end
            ST_T4: begin
               if (is_mul)
                  {ch_q, c_q} <= product;
               if (is_div) begin
                  if (div_zero)
                     div_err <= 1'b1;
                  else begin
                     c_q  <= quotient;
                     ch_q <= remainder;
                  end
               end
               if (is_jpl && con_q)
                  pc <= pc + f_disp;
            end
            default: ;
         endcase
      end
   end

   assign step = st;
endmodule

// File: rtl/seqcpu_checker.sv
module seqcpu_checker #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              busy,
   input logic [2:0]        step,
   input logic [DATA_W-1:0] pc,
   input logic              wb_en,
   input logic [IDX_W-1:0]  wb_idx,
   input logic              div_err
);
   // R1: steps advance by one or wrap to T0
   p_step_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step != 3'd0) |=> (step == 3'd0 || step == 3'($past(step) + 3'd1)));

   // R1: fetch T1 always continues to T2 with pc incremented
   p_fetch_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd1) |=> (step == 3'd2 && pc == DATA_W'($past(pc) + 1'b1)));

   // R9: idle hold at T0
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd0 && !run) |=> (step == 3'd0 && $stable(pc)));

   // R9: busy during execution
   p_busy_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step != 3'd0) |-> busy);

   // R6: pc only moves in T1 (fetch) or T4 (jump)
   p_pc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step != 3'd1 && step != 3'd4) |=> $stable(pc));

   // R5: error flag is sticky
   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |=> div_err);

   // R3: the T5 write always targets R0
   p_hi_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && step == 3'd5) |-> (wb_idx == '0));

   // R11: writes only in the execute window
   p_wb_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (step >= 3'd4 && step <= 3'd6));
endmodule

bind seqcpu_core seqcpu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_seqcpu_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .busy    (busy),
   .step    (step),
   .pc      (pc),
   .wb_en   (wb_en),
   .wb_idx  (wb_idx),
   .div_err (div_err)
);

// File: tb/test_seqcpu_core.sv
module test_seqcpu_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        busy;
   logic [2:0]  step;
   logic [15:0] pc;
   logic        wb_en;
   logic [2:0]  wb_idx;
   logic [15:0] wb_data;
   logic        div_err;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] mem [64];
   logic [2:0]  log_idx [8];
   logic [15:0] log_dat [8];
   int          n_wb = 0;
   logic [15:0] pcm = '0;

   always #4 clk = ~clk;

   seqcpu_core i_seqcpu_core (
      .clk(clk), .rst_n(rst_n), .run(run), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .busy(busy), .step(step), .pc(pc), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_data(wb_data), .div_err(div_err)
   );

   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

   always @(negedge clk) begin
      if (wb_en && n_wb < 8) begin
         log_idx[n_wb] = wb_idx;
         log_dat[n_wb] = wb_data;
         n_wb++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] enc3(input logic [4:0] op, input logic [2:0] ra,
                                        input logic [2:0] rb, input logic [4:0] low);
      return {op, ra, rb, low};
   endfunction

   // run one instruction placed at pcm; check step count, writes and pc
   task automatic exec(input logic [15:0] instr, input int exp_cyc, input int exp_n,
                       input logic [2:0] i0, input logic [15:0] d0,
                       input logic [2:0] i1, input logic [15:0] d1,
                       input logic [15:0] exp_pc, input string tag);
      int cyc;
      mem[pcm[5:0]] = instr;
      @(negedge clk);
      n_wb = 0;
      run = 1'b1;
      cyc = 1;
      @(negedge clk);
      run = 1'b0;
      while (step != 3'd0) begin
         cyc++;
         @(negedge clk);
      end
      chk(cyc == exp_cyc, {tag, " steps"}, cyc, exp_cyc);
      chk(n_wb == exp_n, {tag, " write count"}, n_wb, exp_n);
      if (exp_n > 0 && n_wb > 0) begin
         chk(log_idx[0] == i0, {tag, " first write reg"}, int'(log_idx[0]), int'(i0));
         chk(log_dat[0] == d0, {tag, " first write data"}, int'(log_dat[0]), int'(d0));
      end
      if (exp_n > 1 && n_wb > 1) begin
         chk(log_idx[1] == i1, {tag, " second write reg"}, int'(log_idx[1]), int'(i1));
         chk(log_dat[1] == d1, {tag, " second write data"}, int'(log_dat[1]), int'(d1));
      end
      chk(pc == exp_pc, {tag, " pc"}, int'(pc), int'(exp_pc));
      pcm = exp_pc;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(pc == 16'h0, "R10 reset pc", int'(pc), 0);
      chk(step == 3'd0, "R10 reset step", int'(step), 0);
      chk(!div_err, "R10 reset div_err", int'(div_err), 0);
      chk(!wb_en, "R10 reset wb_en", int'(wb_en), 0);
      chk(!busy, "R9 idle busy low", int'(busy), 0);
   endtask

   task automatic t_idle;
      logic [15:0] p0;
      p0 = pc;
      repeat (5) @(negedge clk);
      chk(step == 3'd0, "R9 idle step held", int'(step), 0);
      chk(pc == p0, "R9 idle pc held", int'(pc), int'(p0));
      chk(!busy, "R9 idle busy", int'(busy), 0);
   endtask

   task automatic t_load;
      // R7, R1, R2: negative offset wraps to 0xFFFF -> word 63
      exec(enc3(5'd29, 3'd7, 3'd0, 5'h1F), 5, 1, 3'd7, 16'd48, 3'd0, 16'h0, pcm + 1, "R7 load neg offset");
      exec(enc3(5'd29, 3'd1, 3'd7, 5'd2), 5, 1, 3'd1, 16'h1234, 3'd0, 16'h0, pcm + 1, "R7 load pos offset");
      exec(enc3(5'd29, 3'd2, 3'd7, 5'h1D), 5, 1, 3'd2, 16'h0100, 3'd0, 16'h0, pcm + 1, "R7 load base minus 3");
   endtask

   task automatic t_mul;
      exec(enc3(5'd7, 3'd3, 3'd1, 5'(2 << 2)), 7, 2, 3'd0, 16'h0012, 3'd3, 16'h3400, pcm + 1, "R3 mul");
      exec(enc3(5'd29, 3'd5, 3'd7, 5'd5), 5, 1, 3'd5, 16'hFFFF, 3'd0, 16'h0, pcm + 1, "R7 load ffff");
      exec(enc3(5'd7, 3'd6, 3'd5, 5'(5 << 2)), 7, 2, 3'd0, 16'hFFFE, 3'd6, 16'h0001, pcm + 1, "R3 mul max");
   endtask

   task automatic t_div;
      exec(enc3(5'd29, 3'd0, 3'd7, 5'd6), 5, 1, 3'd0, 16'h0000, 3'd0, 16'h0, pcm + 1, "R7 load r0");
      exec(enc3(5'd5, 3'd3, 3'd1, 5'(2 << 2)), 7, 2, 3'd0, 16'h0034, 3'd3, 16'h0012, pcm + 1, "R4 div low dividend");
      exec(enc3(5'd5, 3'd4, 3'd1, 5'(2 << 2)), 7, 2, 3'd0, 16'h0034, 3'd4, 16'h3412, pcm + 1, "R4 div r0 upper half");
   endtask

   task automatic t_divzero;
      exec(enc3(5'd29, 3'd6, 3'd7, 5'd6), 5, 1, 3'd6, 16'h0000, 3'd0, 16'h0, pcm + 1, "R7 load zero");
      exec(enc3(5'd5, 3'd4, 3'd1, 5'(6 << 2)), 5, 0, 3'd0, 16'h0, 3'd0, 16'h0, pcm + 1, "R5 div by zero");
      chk(div_err, "R5 div_err set", int'(div_err), 1);
      exec(16'h0000, 3, 0, 3'd0, 16'h0, 3'd0, 16'h0, pcm + 1, "R8 nop opcode 0");
      chk(div_err, "R5 div_err sticky", int'(div_err), 1);
   endtask

   task automatic t_jump;
      // pc 12: r1 positive, +3 -> 16
      exec({5'd16, 3'd1, 8'd3}, 5, 0, 3'd0, 16'h0, 3'd0, 16'h0, pcm + 4, "R6 jump taken");
      // r5 negative: falls through
      exec({5'd16, 3'd5, 8'd3}, 5, 0, 3'd0, 16'h0, 3'd0, 16'h0, pcm + 1, "R6 jump not taken");
      // r6 zero counts as positive, displacement -10
      exec({5'd16, 3'd6, 8'hF6}, 5, 0, 3'd0, 16'h0, 3'd0, 16'h0, pcm + 1 - 16'd10, "R6 jump on zero backward");
      exec(enc3(5'd31, 3'd2, 3'd2, 5'd0), 3, 0, 3'd0, 16'h0, 3'd0, 16'h0, pcm + 1, "R8 nop opcode 31");
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h0;
      mem[63] = 16'd48;
      mem[50] = 16'h1234;
      mem[45] = 16'h0100;
      mem[53] = 16'hFFFF;
      mem[54] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle();
      t_load();
      t_mul();
      t_div();
      t_divzero();
      t_jump();
      t_idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule